// File: doc/BRIEF.md
# I2C Master Byte Buffer and Transfer Tracker

This block is the byte data path between a register bus and an I2C master engine. A single data address serves both directions: a bus write places a byte into an 8-entry transmit queue, and a bus read takes the oldest byte out of an 8-entry receive queue. The engine side uses simple strobes. The engine takes one transmit byte per `eng_tx_take` and delivers one received byte per `eng_rx_put`. Bit shifting, START/STOP generation and the address phase are handled outside this block.

Software programs a receive length and a transmit length. The block counts the bytes that actually move in each direction and pulses `xfer_done` when the count for the active direction reaches its length. The receive length may be rewritten while a read is under way. This lets the first received byte of an SMBus block read set the true total. The transferred-byte counters stay readable after the engine stops.

Top module: `i2cm_byte_path`

## Requirements
- R1: Each queue holds 8 bytes. Register address 5 reads the receive occupancy in bits [7:4] and the transmit occupancy in bits [3:0].
- R2: A bus write to address 0 appends to the transmit queue. A bus read of address 0 returns the oldest receive byte and removes it. Both queues keep first-in first-out order.
- R3: The receive length (address 1) and the transmit length (address 2) are separate 8-bit read/write registers, so each length is at most 255.
- R4: Addresses 3 and 4 read the count of bytes accepted from the engine (receive) and handed to the engine (transmit). Writing the transmit length clears the transmit count, empties the transmit queue and clears the overflow flag. Writing the receive length while no read is in progress clears the receive count and empties the receive queue.
- R5: A read is in progress when the receive count is nonzero and the read has not completed. Rewriting the receive length during a read keeps the count and the queued bytes, and the read then completes at the new total.
- R6: If the rewritten receive length is less than or equal to the bytes already received, `xfer_done` pulses in the cycle after the write, and further received bytes are ignored.
- R7: `tx_service` is high while the transmit queue is not full and transmit count plus transmit occupancy is below the transmit length. `rx_service` is high while the receive queue is not empty.
- R8: `xfer_done` is a one-cycle pulse in the cycle after the byte that brings the count of the direction selected by `eng_dir_rd` (1 = read) to its length. After completion, engine strobes in that direction are ignored and `eng_tx_valid` stays low.
- R9: A data read with the receive queue empty returns 0xFF and leaves occupancy and count unchanged.
- R10: A data write with the transmit queue full is dropped and sets a sticky overflow flag, seen on `tx_overflow` and at address 6 bit 0. If the engine takes a byte in the same cycle, the write is accepted.
- R11: A data read and an engine receive strobe in the same cycle both take effect: the read returns the older byte and occupancy is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops at address 0) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data, valid in the strobe cycle |
| eng_dir_rd | input | 1 | Active direction: 1 read, 0 write |
| eng_tx_take | input | 1 | Engine consumes the offered transmit byte |
| eng_tx_valid | output | 1 | A transmit byte is offered |
| eng_tx_byte | output | 8 | Offered transmit byte |
| eng_rx_put | input | 1 | Engine delivers a received byte |
| eng_rx_byte | input | 8 | Received byte |
| tx_service | output | 1 | Transmit queue wants more bytes |
| rx_service | output | 1 | Receive queue holds bytes |
| xfer_done | output | 1 | Completion pulse for the active direction |
| tx_overflow | output | 1 | Sticky dropped-write flag |

## Verification
Two events can land on the same queue in one cycle. A bus pop and an engine delivery can hit the receive queue together. A bus push at full occupancy and an engine take can hit the transmit queue together. The bench forces each case by raising both strobes in one cycle. It then judges the outcome from the returned byte, the occupancy readback and the byte order the engine later sees. Rewriting the receive length in the same cycle window as a delivery is also covered: the completion pulse must follow the new total and not the old one.

// File: rtl/i2cm_bp_pkg.sv
package i2cm_bp_pkg;
    localparam int DATA_W = 8;
    localparam int LEN_W  = 8;

    typedef enum logic [2:0] {
        REG_DATA  = 3'd0,
        REG_RXLEN = 3'd1,
        REG_TXLEN = 3'd2,
        REG_RXCNT = 3'd3,
        REG_TXCNT = 3'd4,
        REG_LEVEL = 3'd5,
        REG_FLAG  = 3'd6
    } reg_sel_e;

    localparam logic [DATA_W-1:0] EMPTY_READ = 8'hFF;
endpackage

// File: rtl/i2cm_bp_fifo.sv
module i2cm_bp_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty,
    output logic          push_ok,
    output logic          pop_ok
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [LW-1:0]           lvl;
    } fifo_state_t;

    fifo_state_t st_d, st_q;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        full    = (st_q.lvl == LW'(DEPTH));
        empty   = (st_q.lvl == '0);
        pop_ok  = pop && !empty && !flush;
        push_ok = push && !flush && (!full || pop_ok);
        rdata   = st_q.mem[st_q.rp];
        level   = st_q.lvl;

        st_d = st_q;
        if (flush) begin
            st_d.wp  = '0;
            st_d.rp  = '0;
            st_d.lvl = '0;
        end else begin
            if (push_ok) begin
                st_d.mem[st_q.wp] = wdata;
                st_d.wp           = ptr_inc(st_q.wp);
            end
            if (pop_ok) begin
                st_d.rp = ptr_inc(st_q.rp);
            end
            case ({push_ok, pop_ok})
                2'b10:   st_d.lvl = st_q.lvl + 1'b1;
                2'b01:   st_d.lvl = st_q.lvl - 1'b1;
                default: st_d.lvl = st_q.lvl;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R1
    fifo_level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lvl <= LW'(DEPTH));

    // R4
    fifo_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (level == '0));

    // R9
    fifo_empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push && !flush) |=> (level == '0));
endmodule

// File: rtl/i2cm_bp_track.sv
module i2cm_bp_track #(
    parameter int CNT_W    = 8,
    parameter bit RETARGET = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             len_wr,
    input  logic [CNT_W-1:0] len_wdata,
    input  logic             step,
    output logic [CNT_W-1:0] len,
    output logic [CNT_W-1:0] cnt,
    output logic             fin,
    output logic             active,
    output logic             restart,
    output logic             hit
);
    typedef struct packed {
        logic [CNT_W-1:0] len;
        logic [CNT_W-1:0] cnt;
        logic             fin;
    } trk_state_t;

    trk_state_t st_d, st_q;
    logic [CNT_W:0] cnt_after;
    logic [CNT_W:0] eff_len;

    assign active = (st_q.cnt != '0) && !st_q.fin;

    generate
        if (RETARGET) begin : g_retarget
            assign restart = len_wr && !active;
        end else begin : g_plain
            assign restart = len_wr;
        end
    endgenerate

    always_comb begin
        cnt_after = {1'b0, st_q.cnt} + {{CNT_W{1'b0}}, step};
        eff_len   = {1'b0, (len_wr ? len_wdata : st_q.len)};
        hit       = !restart && !st_q.fin && (step || len_wr)
                    && (cnt_after != '0) && (cnt_after >= eff_len);

        st_d = st_q;
        if (restart) begin
            st_d.len = len_wdata;
            st_d.cnt = '0;
            st_d.fin = 1'b0;
        end else begin
            if (len_wr) st_d.len = len_wdata;
            st_d.cnt = cnt_after[CNT_W-1:0];
            st_d.fin = st_q.fin || hit;
        end
    end

    assign len = st_q.len;
    assign cnt = st_q.cnt;
    assign fin = st_q.fin;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !len_wr |=> ((cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1)));

    // R8
    fin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && !len_wr) |=> (fin && $stable(cnt)));
endmodule

// File: rtl/i2cm_byte_path.sv
module i2cm_byte_path
    import i2cm_bp_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    localparam int LW        = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [2:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              eng_dir_rd,
    input  logic              eng_tx_take,
    output logic              eng_tx_valid,
    output logic [DATA_W-1:0] eng_tx_byte,
    input  logic              eng_rx_put,
    input  logic [DATA_W-1:0] eng_rx_byte,
    output logic              tx_service,
    output logic              rx_service,
    output logic              xfer_done,
    output logic              tx_overflow
);
    typedef struct packed {
        logic ovf;
        logic done;
    } top_state_t;

    top_state_t st_d, st_q;

    logic              rx_len_wr, tx_len_wr, rx_pop, tx_push;
    logic [LEN_W-1:0]  rx_len, rx_cnt, tx_len, tx_cnt;
    logic              rx_fin, tx_fin, rx_active, tx_active;
    logic              rx_restart, tx_restart, rx_hit, tx_hit;
    logic [DATA_W-1:0] rx_head;
    logic [LW-1:0]     rx_lvl, tx_lvl;
    logic              rx_full, rx_empty, tx_full, tx_empty;
    logic              rx_push_ok, rx_pop_ok, tx_push_ok, tx_pop_ok;
    logic [LEN_W:0]    tx_planned;

    assign rx_len_wr = bus_wr && (bus_addr == REG_RXLEN);
    assign tx_len_wr = bus_wr && (bus_addr == REG_TXLEN);
    assign tx_push   = bus_wr && (bus_addr == REG_DATA);
    assign rx_pop    = bus_rd && (bus_addr == REG_DATA);

    i2cm_bp_track #(.CNT_W(LEN_W), .RETARGET(1'b1)) u_rx_trk (
        .clk(clk), .rst_n(rst_n), .len_wr(rx_len_wr), .len_wdata(bus_wdata),
        .step(rx_push_ok), .len(rx_len), .cnt(rx_cnt), .fin(rx_fin),
        .active(rx_active), .restart(rx_restart), .hit(rx_hit)
    );

    i2cm_bp_track #(.CNT_W(LEN_W), .RETARGET(1'b0)) u_tx_trk (
        .clk(clk), .rst_n(rst_n), .len_wr(tx_len_wr), .len_wdata(bus_wdata),
        .step(tx_pop_ok), .len(tx_len), .cnt(tx_cnt), .fin(tx_fin),
        .active(tx_active), .restart(tx_restart), .hit(tx_hit)
    );

    i2cm_bp_fifo #(.DEPTH(FIFO_DEPTH), .W(DATA_W)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n), .flush(rx_restart),
        .push(eng_rx_put && !rx_fin), .pop(rx_pop), .wdata(eng_rx_byte),
        .rdata(rx_head), .level(rx_lvl), .full(rx_full), .empty(rx_empty),
        .push_ok(rx_push_ok), .pop_ok(rx_pop_ok)
    );

    i2cm_bp_fifo #(.DEPTH(FIFO_DEPTH), .W(DATA_W)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n), .flush(tx_restart),
        .push(tx_push), .pop(eng_tx_take && eng_tx_valid), .wdata(bus_wdata),
        .rdata(eng_tx_byte), .level(tx_lvl), .full(tx_full), .empty(tx_empty),
        .push_ok(tx_push_ok), .pop_ok(tx_pop_ok)
    );

    always_comb begin
        eng_tx_valid = !tx_empty && !tx_fin;
        rx_service   = !rx_empty;
        tx_planned   = {1'b0, tx_cnt} + (LEN_W+1)'(tx_lvl);
        tx_service   = !tx_full && (tx_planned < {1'b0, tx_len});

        unique case (bus_addr)
            REG_DATA:  bus_rdata = rx_empty ? EMPTY_READ : rx_head;
            REG_RXLEN: bus_rdata = rx_len;
            REG_TXLEN: bus_rdata = tx_len;
            REG_RXCNT: bus_rdata = rx_cnt;
            REG_TXCNT: bus_rdata = tx_cnt;
            REG_LEVEL: bus_rdata = {4'(rx_lvl), 4'(tx_lvl)};
            REG_FLAG:  bus_rdata = {7'd0, st_q.ovf};
            default:   bus_rdata = '0;
        endcase

        st_d.done = eng_dir_rd ? rx_hit : tx_hit;
        if (tx_restart) st_d.ovf = 1'b0;
        else            st_d.ovf = st_q.ovf || (tx_push && !tx_push_ok);
    end

    assign xfer_done   = st_q.done;
    assign tx_overflow = st_q.ovf;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done);

    // R10
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_overflow && !tx_len_wr) |=> tx_overflow);

    // R6
    shrink_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_len_wr && rx_active && eng_dir_rd && (bus_wdata <= rx_cnt)) |=> xfer_done);

    // R7
    tx_service_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_service |-> (tx_lvl < LW'(FIFO_DEPTH)));
endmodule

// File: tb/test_i2cm_byte_path.sv
module test_i2cm_byte_path;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       eng_dir_rd = 1'b0, eng_tx_take = 1'b0, eng_rx_put = 1'b0;
    logic       eng_tx_valid, tx_service, rx_service, xfer_done, tx_overflow;
    logic [7:0] eng_tx_byte, eng_rx_byte = '0;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    logic [7:0] exp_tx[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    i2cm_byte_path i_i2cm_byte_path (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_dir_rd(eng_dir_rd), .eng_tx_take(eng_tx_take),
        .eng_tx_valid(eng_tx_valid), .eng_tx_byte(eng_tx_byte),
        .eng_rx_put(eng_rx_put), .eng_rx_byte(eng_rx_byte),
        .tx_service(tx_service), .rx_service(rx_service),
        .xfer_done(xfer_done), .tx_overflow(tx_overflow)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: compares every byte the engine takes with the queue.
    always @(negedge clk) begin
        if (rst_n && eng_tx_take && eng_tx_valid) begin
            checks++;
            if (exp_tx.size() == 0) begin
                failures++;
                $display("FAIL R2 tx order actual=%0h expected=none", eng_tx_byte);
            end else begin
                logic [7:0] e;
                e = exp_tx.pop_front();
                if (eng_tx_byte !== e) begin
                    failures++;
                    $display("FAIL R2 tx order actual=%0h expected=%0h", eng_tx_byte, e);
                end
            end
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic push(input logic [7:0] d, input bit accept);
        if (accept) exp_tx.push_back(d);
        wr(3'd0, d);
    endtask

    task automatic take();
        eng_tx_take = 1'b1;
        step();
        eng_tx_take = 1'b0;
    endtask

    task automatic put(input logic [7:0] d);
        eng_rx_put = 1'b1; eng_rx_byte = d;
        step();
        eng_rx_put = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // Reset state
        rd(3'd5, v); chk("R1 reset levels", v, 8'h00);
        rd(3'd6, v); chk("R10 reset flag", v, 8'h00);
        chk("R8 reset done", xfer_done, 1'b0);
        chk("R7 reset rx_service", rx_service, 1'b0);
        chk("R7 reset tx_service", tx_service, 1'b0);

        // Transmit path
        eng_dir_rd = 1'b0;
        wr(3'd2, 8'd5);
        rd(3'd2, v); chk("R3 txlen readback", v, 8'd5);
        chk("R7 tx_service room", tx_service, 1'b1);
        push(8'h11, 1); push(8'h22, 1); push(8'h33, 1);
        rd(3'd5, v); chk("R1 tx level 3", v, 8'h03);
        take(); take(); take();
        rd(3'd4, v); chk("R4 tx count 3", v, 8'd3);
        push(8'h44, 1); push(8'h55, 1);
        chk("R7 tx_service no more needed", tx_service, 1'b0);
        take();
        chk("R8 no early done", xfer_done, 1'b0);
        take();
        chk("R8 tx done pulse", xfer_done, 1'b1);
        step();
        chk("R8 tx done one cycle", xfer_done, 1'b0);
        push(8'h66, 0);
        chk("R8 no valid after done", eng_tx_valid, 1'b0);
        take();
        rd(3'd4, v); chk("R8 tx count frozen", v, 8'd5);
        rd(3'd5, v); chk("R8 tx level kept", v, 8'h01);

        // Overflow and push/take collision
        wr(3'd2, 8'd20);
        rd(3'd5, v); chk("R4 tx flush", v, 8'h00);
        rd(3'd4, v); chk("R4 tx count clear", v, 8'd0);
        for (int i = 0; i < 8; i++) push(8'hA0 + 8'(i), 1);
        rd(3'd5, v); chk("R1 tx full level 8", v, 8'h08);
        chk("R7 tx_service full", tx_service, 1'b0);
        push(8'hEE, 0);
        chk("R10 overflow port", tx_overflow, 1'b1);
        rd(3'd6, v); chk("R10 overflow reg", v, 8'h01);
        rd(3'd5, v); chk("R10 dropped level", v, 8'h08);
        exp_tx.push_back(8'hB8);
        bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 8'hB8; eng_tx_take = 1'b1;
        step();
        bus_wr = 1'b0; eng_tx_take = 1'b0;
        rd(3'd5, v); chk("R10 push with take accepted", v, 8'h08);
        for (int i = 0; i < 8; i++) take();
        rd(3'd4, v); chk("R4 tx count 9", v, 8'd9);
        chk("R2 scoreboard drained", exp_tx.size(), 0);
        chk("R10 overflow still set", tx_overflow, 1'b1);
        wr(3'd2, 8'd3);
        chk("R4 overflow cleared", tx_overflow, 1'b0);

        // Receive path
        eng_dir_rd = 1'b1;
        wr(3'd1, 8'd4);
        rd(3'd1, v); chk("R3 rxlen readback", v, 8'd4);
        put(8'h5A); put(8'h6B);
        chk("R7 rx_service", rx_service, 1'b1);
        rd(3'd5, v); chk("R1 rx level 2", v, 8'h20);
        rd(3'd0, v); chk("R2 rx first", v, 8'h5A);
        rd(3'd0, v); chk("R2 rx second", v, 8'h6B);
        chk("R7 rx_service empty", rx_service, 1'b0);
        rd(3'd0, v); chk("R9 empty pop value", v, 8'hFF);
        rd(3'd5, v); chk("R9 empty pop level", v, 8'h00);
        rd(3'd3, v); chk("R9 rx count kept", v, 8'd2);
        put(8'h01);
        chk("R8 rx not yet done", xfer_done, 1'b0);
        put(8'h02);
        chk("R8 rx done pulse", xfer_done, 1'b1);
        rd(3'd0, v); rd(3'd0, v);

        // Block read: first byte sets the length
        wr(3'd1, 8'd10);
        rd(3'd3, v); chk("R4 rx count clear", v, 8'd0);
        put(8'd3);
        wr(3'd1, 8'd4);
        rd(3'd3, v); chk("R5 count kept on retarget", v, 8'd1);
        rd(3'd5, v); chk("R5 fifo kept on retarget", v, 8'h10);
        put(8'hC1); put(8'hC2);
        chk("R5 not done before new total", xfer_done, 1'b0);
        put(8'hC3);
        chk("R5 done at new total", xfer_done, 1'b1);
        put(8'hC4);
        rd(3'd3, v); chk("R8 rx count frozen", v, 8'd4);
        rd(3'd5, v); chk("R8 rx put ignored", v, 8'h40);
        rd(3'd0, v); chk("R2 block length byte", v, 8'd3);

        // Shrink below bytes already received
        wr(3'd1, 8'd10);
        rd(3'd5, v); chk("R4 rx flush", v, 8'h00);
        put(8'hD1); put(8'hD2); put(8'hD3);
        wr(3'd1, 8'd2);
        chk("R6 immediate done", xfer_done, 1'b1);
        put(8'hD4);
        rd(3'd5, v); chk("R6 later put ignored", v, 8'h30);
        rd(3'd3, v); chk("R6 count kept", v, 8'd3);

        // Pop and put in the same cycle
        wr(3'd1, 8'd10);
        put(8'hE1);
        eng_rx_put = 1'b1; eng_rx_byte = 8'hE2;
        rd(3'd0, v);
        eng_rx_put = 1'b0;
        chk("R11 pop returns older", v, 8'hE1);
        rd(3'd5, v); chk("R11 level unchanged", v, 8'h10);
        rd(3'd0, v); chk("R11 newer byte", v, 8'hE2);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule